// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Unit with Carry and Overflow Flags

This unit executes the add and subtract group of a 64-bit fixed-point datapath. Two 64-bit operands, a carry input and a 3-bit operation code go in. The unit registers the 64-bit sum and keeps a 32-bit fixed-point status word. The status word holds a sticky summary-overflow bit plus carry and signed-overflow flags. Each flag is taken at two widths at the same time: out of the full 64-bit sum and out of its low 32 bits. A 4-bit condition field is also kept. When recording is requested, it reports how the 64-bit result compares with zero as a signed number.

Every operation reduces to one addition: a first term, a second term and an incoming carry. The first term is operand A or its bitwise inverse. The second term is operand B or zero. The incoming carry is 0, 1 or the carry input. Separate enables decide whether the carry flags, the overflow flags and the condition field take the new values. The carry input is normally fed from the carry bit of the status word by the surrounding datapath.

Top module: `fxadd_unit`

## Requirements
- R1: For each op code the result is: 0 A+B; 1 B-A (B + not A + 1); 2 A+B+carry_in; 3 B + not A + carry_in; 4 A+carry_in; 5 not A + carry_in; 6 negate A (not A + 1). The result appears on result_q in the cycle after the rising edge that samples in_valid high.
- R2: status_q bit positions: summary overflow at 31, overflow at 30, carry at 29, 32-bit overflow at 19, 32-bit carry at 18. Every other bit reads 0.
- R3: With ca_upd_en high, bit 29 takes the carry out of the 64-bit addition and bit 18 takes the carry out of bit 31. For subtract forms this carry is 1 when no borrow occurs.
- R4: With ov_upd_en high, bit 30 takes the signed overflow of the 64-bit addition and bit 19 takes the signed overflow of the low-32-bit addition.
- R5: An accepted operation that sets bit 30 also sets bit 31. Bit 31 is sticky: only reset clears it.
- R6: With ca_upd_en low, bits 29 and 18 keep their values. With ov_upd_en low, bits 30, 19 and 31 keep their values.
- R7: With rec_en high, cond_q = {LT, GT, EQ, SO} from bit 3 down to bit 0. LT, GT and EQ come from a signed 64-bit compare of the result with zero. SO is the updated bit 31. With rec_en low, cond_q keeps its value.
- R8: In a cycle with in_valid low, or with op code 7, result_q, status_q and cond_q all keep their values.
- R9: A synchronous active-high rst clears result_q, status_q and cond_q to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (see R1; 7 is reserved) |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| carry_in | input | 1 | Carry used by extended and zero-extended forms |
| ca_upd_en | input | 1 | Allow carry flag update |
| ov_upd_en | input | 1 | Allow overflow flag update |
| rec_en | input | 1 | Allow condition field update |
| result_q | output | 64 | Registered result |
| status_q | output | 32 | Fixed-point status word |
| cond_q | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench targets operands where the 32-bit and 64-bit flags differ. One example is a low word of all ones plus one: a design that took both carries from the same bit would report the wrong width. Negating the most negative value must raise overflow, and subtracting equal operands must give carry 1. A design that treated the subtract carry as a borrow would invert the carry in that case. Runs of operations with overflow disabled, or with overflow enabled but no overflow, follow an overflow. A non-sticky summary bit would drop, and a summary bit that ignored the enable would rise. Results with only the top bit set, and the zero result, catch a condition field that compares 32 bits or compares unsigned.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

  localparam int unsigned DATA_W   = 64;
  localparam int unsigned HALF_W   = 32;
  localparam int unsigned STAT_W   = 32;

  localparam int unsigned SO_POS   = 31;
  localparam int unsigned OV_POS   = 30;
  localparam int unsigned CA_POS   = 29;
  localparam int unsigned OV32_POS = 19;
  localparam int unsigned CA32_POS = 18;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUBF   = 3'd1,
    OP_ADDE   = 3'd2,
    OP_SUBFE  = 3'd3,
    OP_ADDZE  = 3'd4,
    OP_SUBFZE = 3'd5,
    OP_NEG    = 3'd6,
    OP_RSVD   = 3'd7
  } fx_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_EXT  = 2'd2
  } cin_src_e;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
  } fx_flags_t;

  function automatic logic signed_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

endpackage

// File: rtl/fxadd_operand_prep.sv
module fxadd_operand_prep
  import fxadd_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  fx_op_e         op,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic           carry_in,
  output logic [W-1:0]   term_x,
  output logic [W-1:0]   term_y,
  output logic           term_c,
  output logic           op_ok
);

  logic     invert_a;
  logic     take_b;
  cin_src_e cin_src;

  always_comb begin
    invert_a = 1'b0;
    take_b   = 1'b0;
    cin_src  = CIN_ZERO;
    op_ok    = 1'b1;
    unique case (op)
      OP_ADD:    begin take_b = 1'b1; cin_src = CIN_ZERO; end
      OP_SUBF:   begin invert_a = 1'b1; take_b = 1'b1; cin_src = CIN_ONE; end
      OP_ADDE:   begin take_b = 1'b1; cin_src = CIN_EXT; end
      OP_SUBFE:  begin invert_a = 1'b1; take_b = 1'b1; cin_src = CIN_EXT; end
      OP_ADDZE:  begin cin_src = CIN_EXT; end
      OP_SUBFZE: begin invert_a = 1'b1; cin_src = CIN_EXT; end
      OP_NEG:    begin invert_a = 1'b1; cin_src = CIN_ONE; end
      default:   op_ok = 1'b0;
    endcase
  end

  assign term_x = invert_a ? ~opnd_a : opnd_a;
  assign term_y = take_b ? opnd_b : '0;

  always_comb begin
    unique case (cin_src)
      CIN_ONE: term_c = 1'b1;
      CIN_EXT: term_c = carry_in;
      default: term_c = 1'b0;
    endcase
  end

endmodule

// File: rtl/fxadd_adder.sv
module fxadd_adder
  import fxadd_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned H = HALF_W
) (
  input  logic [W-1:0] term_x,
  input  logic [W-1:0] term_y,
  input  logic         term_c,
  output logic [W-1:0] sum,
  output fx_flags_t    flags
);

  logic [W:0] full_sum;
  logic [H:0] low_sum;

  assign full_sum = {1'b0, term_x} + {1'b0, term_y} + {{W{1'b0}}, term_c};
  assign low_sum  = {1'b0, term_x[H-1:0]} + {1'b0, term_y[H-1:0]} + {{H{1'b0}}, term_c};
  assign sum      = full_sum[W-1:0];

  assign flags.ca   = full_sum[W];
  assign flags.ca32 = low_sum[H];
  assign flags.ov   = signed_ovf(term_x[W-1], term_y[W-1], full_sum[W-1]);
  assign flags.ov32 = signed_ovf(term_x[H-1], term_y[H-1], low_sum[H-1]);

endmodule

// File: rtl/fxadd_state.sv
module fxadd_state
  import fxadd_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic          ca_upd_en,
  input  logic          ov_upd_en,
  input  logic          rec_en,
  input  logic [W-1:0]  sum,
  input  fx_flags_t     flags,
  output logic          so_next,
  output logic [W-1:0]  result_q,
  output logic [SW-1:0] status_q,
  output logic [3:0]    cond_q
);

  logic so_r, ov_r, ca_r, ov32_r, ca32_r;
  logic is_neg, is_zero, is_pos;

  assign so_next = so_r | (ov_upd_en & flags.ov);
  assign is_neg  = sum[W-1];
  assign is_zero = (sum == '0);
  assign is_pos  = !is_neg && !is_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      so_r     <= 1'b0;
      ov_r     <= 1'b0;
      ca_r     <= 1'b0;
      ov32_r   <= 1'b0;
      ca32_r   <= 1'b0;
      cond_q   <= '0;
    end else if (upd) begin
      result_q <= sum;
      if (ca_upd_en) begin
        ca_r   <= flags.ca;
        ca32_r <= flags.ca32;
      end
      if (ov_upd_en) begin
        ov_r   <= flags.ov;
        ov32_r <= flags.ov32;
        so_r   <= so_next;
      end
      if (rec_en) begin
        cond_q <= {is_neg, is_pos, is_zero, so_next};
      end
    end
  end

  always_comb begin
    status_q           = '0;
    status_q[SO_POS]   = so_r;
    status_q[OV_POS]   = ov_r;
    status_q[CA_POS]   = ca_r;
    status_q[OV32_POS] = ov32_r;
    status_q[CA32_POS] = ca32_r;
  end

endmodule

// File: rtl/fxadd_unit.sv
module fxadd_unit
  import fxadd_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned H  = HALF_W,
  parameter int unsigned SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          carry_in,
  input  logic          ca_upd_en,
  input  logic          ov_upd_en,
  input  logic          rec_en,
  output logic [W-1:0]  result_q,
  output logic [SW-1:0] status_q,
  output logic [3:0]    cond_q
);

  logic [W-1:0] term_x, term_y, sum_w;
  logic         term_c, op_ok_w, upd_w, so_next_w, ov64_w;
  fx_flags_t    flags_w;

  fxadd_operand_prep #(.W(W)) u_prep (
    .op       (fx_op_e'(op)),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .term_x   (term_x),
    .term_y   (term_y),
    .term_c   (term_c),
    .op_ok    (op_ok_w)
  );

  fxadd_adder #(.W(W), .H(H)) u_add (
    .term_x (term_x),
    .term_y (term_y),
    .term_c (term_c),
    .sum    (sum_w),
    .flags  (flags_w)
  );

  assign upd_w  = in_valid && op_ok_w;
  assign ov64_w = flags_w.ov;

  fxadd_state #(.W(W), .SW(SW)) u_state (
    .clk       (clk),
    .rst       (rst),
    .upd       (upd_w),
    .ca_upd_en (ca_upd_en),
    .ov_upd_en (ov_upd_en),
    .rec_en    (rec_en),
    .sum       (sum_w),
    .flags     (flags_w),
    .so_next   (so_next_w),
    .result_q  (result_q),
    .status_q  (status_q),
    .cond_q    (cond_q)
  );

endmodule

// File: rtl/fxadd_unit_chk.sv
module fxadd_unit_chk
  import fxadd_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned SW = STAT_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic          ca_upd_en,
  input logic          ov_upd_en,
  input logic          rec_en,
  input logic [W-1:0]  result_q,
  input logic [SW-1:0] status_q,
  input logic [3:0]    cond_q,
  input logic          upd_w,
  input logic          so_next_w,
  input logic          ov64_w
);

  localparam logic [SW-1:0] USED_MASK =
    (SW'(1) << SO_POS) | (SW'(1) << OV_POS) | (SW'(1) << CA_POS) |
    (SW'(1) << OV32_POS) | (SW'(1) << CA32_POS);

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~USED_MASK) == '0);

  // R5
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[SO_POS] |=> status_q[SO_POS]);

  // R5
  ov_implies_so_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[OV_POS] |-> status_q[SO_POS]);

  // R5
  ov_event_sets_so_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_w && ov_upd_en && ov64_w) |=> status_q[SO_POS]);

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ca_upd_en |=> ($stable(status_q[CA_POS]) && $stable(status_q[CA32_POS])));

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ov_upd_en |=> ($stable(status_q[OV_POS]) && $stable(status_q[OV32_POS]) &&
                    $stable(status_q[SO_POS])));

  // R7
  cond_so_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_w && rec_en) |=> (cond_q[0] == status_q[SO_POS]));

  // R7
  cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rec_en |=> $stable(cond_q));

  // R7
  cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(cond_q[3:1]) <= 1);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op == 3'd7) |=> ($stable(result_q) && $stable(status_q) && $stable(cond_q)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result_q == '0 && status_q == '0 && cond_q == '0));

  // R5
  so_next_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_w && ov_upd_en) |=> (status_q[SO_POS] == $past(so_next_w)));

endmodule

bind fxadd_unit fxadd_unit_chk u_chk (.*);

// File: tb/fxadd_unit_test.sv
module fxadd_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [63:0] opnd_a, opnd_b;
  logic        carry_in, ca_upd_en, ov_upd_en, rec_en;
  logic [63:0] result_q;
  logic [31:0] status_q;
  logic [3:0]  cond_q;

  int vectors  = 0;
  int mismatch = 0;
  bit done     = 1'b0;

  logic [63:0] m_res;
  logic        m_so, m_ov, m_ca, m_ov32, m_ca32;
  logic [3:0]  m_cond;

  always #5 clk = ~clk;

  fxadd_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .ca_upd_en(ca_upd_en), .ov_upd_en(ov_upd_en), .rec_en(rec_en),
    .result_q(result_q), .status_q(status_q), .cond_q(cond_q)
  );

  // Reference model: arithmetic done with wide signed/unsigned math.
  task automatic model_step(input logic r, input logic v, input logic [2:0] o,
                            input logic [63:0] a, input logic [63:0] b, input logic ci,
                            input logic cen, input logic oen, input logic ren);
    logic [63:0] x, y;
    logic        c;
    logic [64:0] wide;
    longint unsigned lo_u;
    logic signed [65:0] s64;
    longint      s32;
    logic        ov64, ov32;
    if (r) begin
      m_res = '0; m_so = 0; m_ov = 0; m_ca = 0; m_ov32 = 0; m_ca32 = 0; m_cond = '0;
      return;
    end
    if (!v || o == 3'd7) return;
    case (o)
      3'd0: begin x = a;  y = b;   c = 1'b0; end
      3'd1: begin x = ~a; y = b;   c = 1'b1; end
      3'd2: begin x = a;  y = b;   c = ci;   end
      3'd3: begin x = ~a; y = b;   c = ci;   end
      3'd4: begin x = a;  y = '0;  c = ci;   end
      3'd5: begin x = ~a; y = '0;  c = ci;   end
      default: begin x = ~a; y = '0; c = 1'b1; end
    endcase
    wide = 65'(x) + 65'(y) + 65'(c);
    lo_u = longint'(x[31:0]) + longint'(y[31:0]) + longint'(c);
    s64  = 66'($signed(x)) + 66'($signed(y)) + 66'(c);
    s32  = longint'($signed(x[31:0])) + longint'($signed(y[31:0])) + longint'(c);
    ov64 = (s64 > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (s64 < -66'sh0_8000_0000_0000_0000);
    ov32 = (s32 > 64'sd2147483647) || (s32 < -64'sd2147483648);
    m_res = wide[63:0];
    if (cen) begin m_ca = wide[64]; m_ca32 = lo_u[32]; end
    if (oen) begin m_ov = ov64; m_ov32 = ov32; m_so = m_so | ov64; end
    if (ren) m_cond = {$signed(m_res) < 0, $signed(m_res) > 0, m_res == 0, m_so};
  endtask

  task automatic apply(input string tag, input logic r, input logic v, input logic [2:0] o,
                       input logic [63:0] a, input logic [63:0] b, input logic ci,
                       input logic cen, input logic oen, input logic ren);
    logic [31:0] exp_st;
    bit bad;
    rst = r; in_valid = v; op = o; opnd_a = a; opnd_b = b; carry_in = ci;
    ca_upd_en = cen; ov_upd_en = oen; rec_en = ren;
    @(posedge clk);
    model_step(r, v, o, a, b, ci, cen, oen, ren);
    @(negedge clk);
    exp_st = '0;
    exp_st[31] = m_so; exp_st[30] = m_ov; exp_st[29] = m_ca;
    exp_st[19] = m_ov32; exp_st[18] = m_ca32;
    vectors++;
    bad = 0;
    if (result_q !== m_res) begin
      bad = 1;
      $display("FAIL %s result (R1): got %h expected %h", tag, result_q, m_res);
    end
    if (status_q !== exp_st) begin
      bad = 1;
      $display("FAIL %s status: got %h expected %h", tag, status_q, exp_st);
    end
    if (cond_q !== m_cond) begin
      bad = 1;
      $display("FAIL %s cond (R7): got %b expected %b", tag, cond_q, m_cond);
    end
    if (bad) mismatch++;
  endtask

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  initial begin
    #2_000_000;
    if (!done) begin
      mismatch++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, mismatch);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; op = 0; opnd_a = 0; opnd_b = 0; carry_in = 0;
    ca_upd_en = 0; ov_upd_en = 0; rec_en = 0;
    @(negedge clk);
    // R9 reset state
    apply("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R9", 1, 1, 0, 64'd5, 64'd6, 0, 1, 1, 1);
    // R3 carry out of 64 bits, zero result EQ
    apply("R3", 0, 1, 3'd0, ALL1, 64'd1, 0, 1, 1, 1);
    // R3 carry out of bit 31 only
    apply("R3", 0, 1, 3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 1, 1);
    // R4 32-bit overflow only, summary stays low
    apply("R4", 0, 1, 3'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 1, 1, 1);
    // R4 R5 64-bit overflow raises summary, LT
    apply("R4", 0, 1, 3'd0, MAXP, 64'd1, 0, 1, 1, 1);
    // R5 overflow enabled without overflow: OV clears, summary stays
    apply("R5", 0, 1, 3'd0, 64'd2, 64'd3, 0, 1, 1, 1);
    // R6 overflow disabled, flags held
    apply("R6", 0, 1, 3'd0, MAXP, 64'd1, 0, 1, 0, 1);
    // R9 clear again
    apply("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 R3 subtract equal operands: zero, carry 1
    apply("R3", 0, 1, 3'd1, 64'd77, 64'd77, 0, 1, 1, 1);
    // R1 subtract with borrow: carry 0, LT
    apply("R1", 0, 1, 3'd1, 64'd9, 64'd4, 0, 1, 1, 1);
    // R1 extended forms with carry_in 1 and 0
    apply("R1", 0, 1, 3'd2, 64'h1234, 64'h1000, 1, 1, 1, 1);
    apply("R1", 0, 1, 3'd3, 64'd10, 64'd30, 0, 1, 1, 1);
    apply("R1", 0, 1, 3'd4, ALL1, 64'hDEAD, 1, 1, 1, 1);
    apply("R1", 0, 1, 3'd5, 64'd0, 64'hBEEF, 0, 1, 1, 1);
    // R1 R4 negate most negative overflows
    apply("R4", 0, 1, 3'd6, MINN, 64'd0, 0, 1, 1, 1);
    apply("R1", 0, 1, 3'd6, 64'd1, 64'd0, 0, 1, 1, 1);
    // R7 only top bit set: LT
    apply("R7", 0, 1, 3'd0, MINN, 64'd0, 0, 0, 0, 1);
    // R7 GT on 32-bit negative but 64-bit positive
    apply("R7", 0, 1, 3'd0, 64'h0000_0000_8000_0000, 64'd0, 0, 0, 0, 1);
    // R7 record disabled holds cond
    apply("R7", 0, 1, 3'd0, 64'd0, 64'd0, 0, 1, 1, 0);
    // R6 carry disabled holds carries
    apply("R6", 0, 1, 3'd0, ALL1, ALL1, 0, 0, 1, 1);
    // R8 idle and reserved op change nothing
    apply("R8", 0, 0, 3'd0, ALL1, 64'd1, 1, 1, 1, 1);
    apply("R8", 0, 1, 3'd7, MAXP, 64'd1, 1, 1, 1, 1);
    // R2 random mix
    for (int i = 0; i < 600; i++) begin
      logic [63:0] ra, rb;
      int sel;
      sel = int'($urandom % 6);
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (sel == 0) ra = MAXP;
      if (sel == 1) rb = MINN;
      if (sel == 2) ra = {32'h0, $urandom};
      apply("R2", ($urandom % 97) == 0, ($urandom % 5) != 0, 3'($urandom), ra, rb,
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, mismatch);
    $finish;
  end

endmodule